// File: doc/BRIEF.md
# Address-Window Breakpoint Counter

This block watches a stream of memory accesses, each with a valid strobe, a read/write flag and an address. Two programmable limits form an inclusive address window. An access counts toward a breakpoint only when it falls inside the window and matches the access type chosen in a 2-bit event-select field. A down-counter holds the number of matching accesses still to be allowed through.

Software loads the counter with one less than the number of matching accesses it wants to see. Each matching access lowers the counter by one. When the counter is already zero, the next matching access raises a one-cycle debug-entry request. The request also sets a sticky status bit. The block then stays disarmed until the counter is written again. A write to the counter is the re-arm point after any change to the limits or to the event selection.

Top module: `abk_range_bkpt`

## Requirements
- R1: An access is inside the window when lower limit <= address and address <= upper limit. Both bounds are inclusive. An address one below the lower limit, or one above the upper limit, never counts.
- R2: Event select encoding: 2'b00 nothing counts, 2'b01 only writes count (acc_write=1), 2'b10 only reads count (acc_write=0), 2'b11 any in-window access counts.
- R3: Each matching access at a non-zero count lowers the 24-bit counter by exactly one. The new value can be read back on the next cycle.
- R4: A matching access that arrives while the counter is zero and the block is armed drives dbg_req high for exactly one cycle, on the cycle after that access. The counter stays at zero, and the block is disarmed: later accesses have no effect until the counter is written or cleared.
- R5: The sticky bit (control bit 2) is set at the same edge that raises dbg_req. It is cleared by reg_clr to the control address or by any write or clear of the counter.
- R6: A write or clear of the counter loads the value (or zero), re-arms the block and clears the sticky bit. If an access arrives in the same cycle, that access is ignored.
- R7: After reset the counter, both limits, the event select and the sticky bit are zero, and the block is armed.
- R8: Register addresses on reg_addr: 0 upper limit, 1 lower limit, 2 counter, 3 control. The control word is {armed at bit 3, sticky at bit 2, event select at bits 1:0}, and a control write changes only the event select. reg_rdata shows the addressed register combinationally, zero-extended. reg_clr zeroes the addressed register; on the control address it clears only the sticky bit. When reg_clr and reg_wr are both asserted, reg_clr wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Memory access present this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | ADDR_W | Access address |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_clr | input | 1 | Register clear strobe |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Read data of the addressed register |
| dbg_req | output | 1 | One-cycle debug-entry request |

## Verification
A wrong comparator bound or a wrong select decode changes the counter readback on the cycle after the access that should, or should not, have counted. The scoreboard catches this on every read. A counter that is off by one, or that fails to disarm, shows up as a dbg_req pulse one access early or late, or as a second pulse. The bench compares every cycle against a queued expectation, so such a fault is flagged within one clock of its cause. Write priority and sticky handling are checked in the cycle right after the colliding stimulus.

// File: rtl/abk_pkg.sv
package abk_pkg;
   typedef enum logic [1:0] {
      EV_OFF = 2'b00,
      EV_WR  = 2'b01,
      EV_RD  = 2'b10,
      EV_ANY = 2'b11
   } ev_sel_e;

   typedef enum logic [1:0] {
      RA_UPPER = 2'd0,
      RA_LOWER = 2'd1,
      RA_COUNT = 2'd2,
      RA_CTRL  = 2'd3
   } reg_addr_e;

   localparam int CTRL_STICKY_BIT = 2;
   localparam int CTRL_ARMED_BIT  = 3;
endpackage

// File: rtl/abk_limit_cmp.sv
module abk_limit_cmp #(
   parameter int ADDR_W   = 16,
   parameter bit IS_UPPER = 1'b1
) (
   input  logic [ADDR_W-1:0] limit,
   input  logic [ADDR_W-1:0] addr,
   output logic              ok
);
   generate
      if (IS_UPPER) begin : g_upper
         assign ok = (limit >= addr);
      end else begin : g_lower
         assign ok = (limit <= addr);
      end
   endgenerate
endmodule

// File: rtl/abk_event_qual.sv
module abk_event_qual
   import abk_pkg::*;
(
   input  logic    valid,
   input  logic    is_write,
   input  logic    hi_ok,
   input  logic    lo_ok,
   input  ev_sel_e sel,
   output logic    qual
);
   logic type_ok;

   always_comb begin
      unique case (sel)
         EV_WR:   type_ok = is_write;
         EV_RD:   type_ok = !is_write;
         EV_ANY:  type_ok = 1'b1;
         default: type_ok = 1'b0;
      endcase
   end

   assign qual = valid && hi_ok && lo_ok && type_ok;
endmodule

// File: rtl/abk_occ_counter.sv
module abk_occ_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             hit,
   output logic [CNT_W-1:0] count,
   output logic             armed,
   output logic             trip_now,
   output logic             trip_q
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   assign trip_now = !load && hit && armed && (count == ZERO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count  <= ZERO;
         armed  <= 1'b1;
         trip_q <= 1'b0;
      end else begin
         trip_q <= trip_now;
         if (load) begin
            count <= load_val;
            armed <= 1'b1;
         end else if (trip_now) begin
            armed <= 1'b0;
         end else if (hit && armed) begin
            count <= count - ONE;
         end
      end
   end
endmodule

// File: rtl/abk_range_bkpt.sv
module abk_range_bkpt
   import abk_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_clr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   output logic              dbg_req
);
   localparam int CTRL_W = CTRL_ARMED_BIT + 1;

   generate
      if (ADDR_W < 1 || ADDR_W > CNT_W) begin : g_bad_addr_w
         $error("abk_range_bkpt: ADDR_W must lie in 1..CNT_W");
      end
      if (CNT_W < CTRL_W) begin : g_bad_cnt_w
         $error("abk_range_bkpt: CNT_W too narrow for control word");
      end
   endgenerate

   logic [ADDR_W-1:0] upper_q, lower_q;
   ev_sel_e           sel_q;
   logic              sticky_q;
   logic              hi_ok, lo_ok, qual;
   logic              cnt_load;
   logic [CNT_W-1:0]  cnt_val, cnt_load_val;
   logic              armed, trip_now, trip_q;

   wire acc_reg = reg_wr || reg_clr;
   wire at_up   = (reg_addr == RA_UPPER);
   wire at_lo   = (reg_addr == RA_LOWER);
   wire at_cnt  = (reg_addr == RA_COUNT);
   wire at_ctl  = (reg_addr == RA_CTRL);

   assign cnt_load     = acc_reg && at_cnt;
   assign cnt_load_val = reg_clr ? '0 : reg_wdata;

   abk_limit_cmp #(.ADDR_W(ADDR_W), .IS_UPPER(1'b1)) u_hi (
      .limit(upper_q), .addr(acc_addr), .ok(hi_ok));
   abk_limit_cmp #(.ADDR_W(ADDR_W), .IS_UPPER(1'b0)) u_lo (
      .limit(lower_q), .addr(acc_addr), .ok(lo_ok));

   abk_event_qual u_qual (
      .valid(acc_valid), .is_write(acc_write),
      .hi_ok(hi_ok), .lo_ok(lo_ok), .sel(sel_q), .qual(qual));

   abk_occ_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(cnt_load), .load_val(cnt_load_val), .hit(qual),
      .count(cnt_val), .armed(armed),
      .trip_now(trip_now), .trip_q(trip_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upper_q  <= '0;
         lower_q  <= '0;
         sel_q    <= EV_OFF;
         sticky_q <= 1'b0;
      end else begin
         if (acc_reg && at_up)
            upper_q <= reg_clr ? '0 : reg_wdata[ADDR_W-1:0];
         if (acc_reg && at_lo)
            lower_q <= reg_clr ? '0 : reg_wdata[ADDR_W-1:0];
         if (reg_wr && !reg_clr && at_ctl)
            sel_q <= ev_sel_e'(reg_wdata[1:0]);
         if (cnt_load)
            sticky_q <= 1'b0;
         else if (trip_now)
            sticky_q <= 1'b1;
         else if (reg_clr && at_ctl)
            sticky_q <= 1'b0;
      end
   end

   logic [CTRL_W-1:0] ctrl_word;
   always_comb begin
      ctrl_word                  = '0;
      ctrl_word[1:0]             = sel_q;
      ctrl_word[CTRL_STICKY_BIT] = sticky_q;
      ctrl_word[CTRL_ARMED_BIT]  = armed;
   end

   always_comb begin
      unique case (reg_addr)
         RA_UPPER: reg_rdata = CNT_W'(upper_q);
         RA_LOWER: reg_rdata = CNT_W'(lower_q);
         RA_COUNT: reg_rdata = cnt_val;
         default:  reg_rdata = CNT_W'(ctrl_word);
      endcase
   end

   assign dbg_req = trip_q;
endmodule

// File: rtl/abk_range_bkpt_chk.sv
module abk_range_bkpt_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [ADDR_W-1:0] upper_q,
   input logic [ADDR_W-1:0] lower_q,
   input logic              qual,
   input logic              armed,
   input logic              cnt_load,
   input logic [CNT_W-1:0]  cnt_load_val,
   input logic [CNT_W-1:0]  cnt_val,
   input logic              sticky_q,
   input logic              dbg_req
);
   // R1: a counted access lies inside the inclusive window
   p_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      qual |-> (acc_valid && acc_addr <= upper_q && acc_addr >= lower_q));

   // R3: a counted access at a non-zero count lowers it by one
   p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && armed && !cnt_load && cnt_val != '0) |=> (cnt_val == $past(cnt_val) - 1'b1));

   // R4: the request is a single-cycle pulse
   p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req |=> !dbg_req);

   // R4: after a request the block is disarmed
   p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_req) |-> !armed);

   // R5: sticky accompanies the request
   p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req |-> sticky_q);

   // R6: counter write wins and re-arms
   p_write_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load |=> (cnt_val == $past(cnt_load_val) && armed && !dbg_req && !sticky_q));
endmodule

bind abk_range_bkpt abk_range_bkpt_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .acc_addr(acc_addr), .upper_q(upper_q), .lower_q(lower_q), .qual(qual),
   .armed(armed), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
   .cnt_val(cnt_val), .sticky_q(sticky_q), .dbg_req(dbg_req));

// File: tb/abk_range_bkpt_test.sv
module abk_range_bkpt_test;
   localparam int AW = 16;
   localparam int CW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0, acc_write = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [1:0]    reg_addr = 2'd0;
   logic          reg_wr = 1'b0, reg_clr = 1'b0;
   logic [CW-1:0] reg_wdata = '0;
   logic [CW-1:0] reg_rdata;
   logic          dbg_req;

   abk_range_bkpt #(.ADDR_W(AW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_clr(reg_clr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_req(dbg_req));

   always #2 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      bit    req;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   // reference model state
   logic [AW-1:0] m_up = '0, m_lo = '0;
   logic [1:0]    m_sel = 2'b00;
   logic [CW-1:0] m_cnt = '0;
   bit            m_armed = 1'b1, m_sticky = 1'b0;

   task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops one expectation per driven cycle
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check(e.tag, {23'd0, dbg_req}, {23'd0, e.req});
      end
   end

   // driver: one clock of stimulus, model update, expected pulse pushed
   task automatic cyc(input bit v, input bit w, input logic [AW-1:0] a,
                      input bit rw, input bit rc, input logic [1:0] ra,
                      input logic [CW-1:0] wd, input string tag);
      bit req, load, in_win, type_ok;
      exp_t e;
      @(negedge clk);
      acc_valid = v; acc_write = w; acc_addr = a;
      reg_wr = rw; reg_clr = rc; reg_addr = ra; reg_wdata = wd;
      @(posedge clk);
      req = 1'b0;
      load = (rw || rc) && ra == 2'd2;
      in_win = (m_lo <= a) && (a <= m_up);
      case (m_sel)
         2'b01: type_ok = w;
         2'b10: type_ok = !w;
         2'b11: type_ok = 1'b1;
         default: type_ok = 1'b0;
      endcase
      if (load) begin
         m_cnt = rc ? '0 : wd; m_armed = 1'b1; m_sticky = 1'b0;
      end else if (v && in_win && type_ok && m_armed) begin
         if (m_cnt == '0) begin
            req = 1'b1; m_armed = 1'b0; m_sticky = 1'b1;
         end else m_cnt = m_cnt - 1'b1;
      end else if (rc && ra == 2'd3) m_sticky = 1'b0;
      if (rw || rc) begin
         if (ra == 2'd0) m_up = rc ? '0 : wd[AW-1:0];
         if (ra == 2'd1) m_lo = rc ? '0 : wd[AW-1:0];
         if (ra == 2'd3 && rw && !rc) m_sel = wd[1:0];
      end
      e.req = req; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic acc(input bit w, input logic [AW-1:0] a, input string tag);
      cyc(1'b1, w, a, 1'b0, 1'b0, 2'd0, '0, tag);
   endtask

   task automatic wreg(input logic [1:0] ra, input logic [CW-1:0] wd, input string tag);
      cyc(1'b0, 1'b0, '0, 1'b1, 1'b0, ra, wd, tag);
   endtask

   task automatic creg(input logic [1:0] ra, input string tag);
      cyc(1'b0, 1'b0, '0, 1'b0, 1'b1, ra, '0, tag);
   endtask

   task automatic rd(input logic [1:0] ra, input logic [CW-1:0] exp, input string tag);
      @(negedge clk);
      acc_valid = 1'b0; reg_wr = 1'b0; reg_clr = 1'b0; reg_addr = ra;
      #1 check(tag, reg_rdata, exp);
   endtask

   function automatic logic [CW-1:0] ctl_exp();
      return {20'd0, m_armed, m_sticky, m_sel};
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R7 reset state
      rd(2'd0, 24'h0, "R7 upper");
      rd(2'd1, 24'h0, "R7 lower");
      rd(2'd2, 24'h0, "R7 count");
      rd(2'd3, 24'h8, "R7 control armed only");

      // R8 register writes and readback
      wreg(2'd0, 24'h001000, "R8");
      wreg(2'd1, 24'h000100, "R8");
      wreg(2'd3, 24'h000001, "R8");
      wreg(2'd2, 24'h000002, "R8");
      rd(2'd0, 24'h001000, "R8 upper readback");
      rd(2'd1, 24'h000100, "R8 lower readback");
      rd(2'd3, 24'h000009, "R8 control readback");

      // R1 window edges, R2 write-only select
      acc(1'b1, 16'h0100, "R1 lower bound");
      rd(2'd2, 24'h1, "R3 first decrement");
      acc(1'b1, 16'h00FF, "R1 below");
      acc(1'b1, 16'h1001, "R1 above");
      acc(1'b0, 16'h0800, "R2 read ignored");
      rd(2'd2, 24'h1, "R1 R2 ignored accesses");
      acc(1'b1, 16'h1000, "R1 upper bound");
      rd(2'd2, 24'h0, "R3 second decrement");
      acc(1'b1, 16'h0800, "R4 trip");
      acc(1'b1, 16'h0800, "R4 disarmed no pulse");
      rd(2'd2, 24'h0, "R4 count stays zero");
      rd(2'd3, 24'h5, "R5 sticky set disarmed");

      // R5 sticky clear
      creg(2'd3, "R5");
      rd(2'd3, ctl_exp(), "R5 sticky cleared");
      check("R5 sticky value", ctl_exp(), 24'h1);

      // R6 write with simultaneous matching access
      cyc(1'b1, 1'b1, 16'h0800, 1'b1, 1'b0, 2'd2, 24'h0, "R6 collision no pulse");
      rd(2'd2, 24'h0, "R6 count after collision");
      rd(2'd3, 24'h9, "R6 re-armed");
      acc(1'b1, 16'h0800, "R6 trip after rearm");
      rd(2'd3, 24'h5, "R5 sticky after trip");
      wreg(2'd2, 24'h1, "R6 write clears sticky");
      rd(2'd3, 24'h9, "R6 sticky cleared by counter write");

      // R2 read-only select
      wreg(2'd3, 24'h2, "R2");
      acc(1'b1, 16'h0200, "R2 write ignored");
      rd(2'd2, 24'h1, "R2 read-only ignores write");
      acc(1'b0, 16'h0200, "R2 read counts");
      acc(1'b0, 16'h0200, "R2 read trips");
      // R2 any select
      wreg(2'd2, 24'h1, "R2");
      wreg(2'd3, 24'h3, "R2");
      acc(1'b1, 16'h0300, "R2 any write");
      acc(1'b0, 16'h0300, "R2 any read trips");
      // R2 disabled
      wreg(2'd2, 24'h0, "R2");
      wreg(2'd3, 24'h0, "R2");
      acc(1'b1, 16'h0300, "R2 off write");
      acc(1'b0, 16'h0300, "R2 off read");
      rd(2'd3, 24'h8, "R2 off nothing counted");

      // R3 full-width counter, R8 clear
      wreg(2'd3, 24'h3, "R3");
      wreg(2'd2, 24'hFFFFFF, "R3");
      acc(1'b0, 16'h0400, "R3 wide");
      rd(2'd2, 24'hFFFFFE, "R3 full-width decrement");
      creg(2'd2, "R8");
      rd(2'd2, 24'h0, "R8 counter clear");
      creg(2'd0, "R8");
      rd(2'd0, 24'h0, "R8 upper clear");
      acc(1'b1, 16'h0100, "R1 empty window");
      rd(2'd3, 24'hB, "R1 nothing counted in empty window");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule